// File: doc/BRIEF.md
# Scan Chain Flush Tester

This block checks that one or more scan shift registers shift cleanly before any scan vectors are loaded into them. When started, it puts every chain into scan mode by holding the shared test-control line low. It then drives the same period-four stream of bits into every scan input: two zeros followed by two ones, repeated. In each chain, every cell therefore sees a 0-to-0, 0-to-1, 1-to-1 and 1-to-0 step as the stream passes through.

The run lasts the chain length plus four clocks. While the stream is still filling a chain, whatever the chain held before comes out of its scan output, and the block disregards those bits. Once the first driven bit reaches the far end, each scan output is compared with the bit that was driven in one chain length earlier. A single mismatch on any chain sets a sticky fail flag. A one-cycle done pulse closes the run. A stuck-at or inverting cell anywhere in a chain shows up as a failure by the end of the same run.

Top module: `scan_flush_tester`

## Requirements
- R1: After reset, busy_o, done_o and fail_o are 0, test_ctrl_o is 1 (normal mode) and every scan_in_o bit is 0.
- R2: A start_i sampled high while idle makes busy_o 1 and test_ctrl_o 0 for exactly CHAIN_LEN+4 cycles. test_ctrl_o is 1 whenever busy_o is 0.
- R3: In run cycle k (k = 0 on the first busy cycle), every scan_in_o bit equals bit 1 of k, which gives the stream 0,0,1,1,0,0,... The same value goes to all chains, and all bits are 0 while idle.
- R4: scan_out_i is compared only in run cycles CHAIN_LEN to CHAIN_LEN+3, against the bit driven CHAIN_LEN cycles earlier. Scan outputs in cycles 0 to CHAIN_LEN-1 have no effect on fail_o.
- R5: done_o is 1 for exactly one cycle, in the cycle right after the last run cycle, and busy_o is 0 in that cycle.
- R6: fail_o is 1 in the done cycle if any compared bit on any chain mismatched. It then holds its value while idle and is cleared when the next start is accepted.
- R7: start_i while busy_o is 1 is ignored, so the run keeps its original end cycle.
- R8: A cell stuck at 0, stuck at 1 or inverting its data, at any position of any chain, makes fail_o 1 at the end of the run.
- R9: Over one run, every cell of a fault-free chain stores all four transitions 00, 01, 11 and 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock shared with the scan chains |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a flush run when idle |
| scan_out_i | input | NUM_CHAINS | Serial output of each chain |
| scan_in_o | output | NUM_CHAINS | Serial input driven into each chain |
| test_ctrl_o | output | 1 | Shared test control, 0 = scan mode |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |
| fail_o | output | 1 | Sticky mismatch flag over all chains |

## Verification
If the run counter is wrong, busy_o and test_ctrl_o stop matching CHAIN_LEN+4 cycles, and done_o arrives at the wrong edge. This is visible as soon as the run ends. A wrong pattern phase or a wrong reference offset shows up at scan_in_o in the first four run cycles, or as a false fail_o at the done pulse. Each fault-injection run also shows whether the compare window misses real errors: a stuck or inverting cell must raise fail_o by the done cycle of that same run. A sticky flag that was never cleared shows up as fail_o still high after a clean run that follows a failing one.

// File: rtl/scan_flush_pkg.sv
`timescale 1ns/1ps
package scan_flush_pkg;
  typedef enum logic {SEQ_IDLE, SEQ_RUN} seq_state_e;

  // period-4 stream 0,0,1,1 indexed by run cycle
  function automatic logic flush_bit(input int unsigned k);
    return k[1];
  endfunction
endpackage

// File: rtl/flush_seq.sv
`timescale 1ns/1ps
module flush_seq import scan_flush_pkg::*; #(
  parameter int unsigned CHAIN_LEN = 16,
  parameter int unsigned CW        = $clog2(CHAIN_LEN + 4)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  output logic          busy_o,
  output logic          done_o,
  output logic          clr_o,
  output logic          cmp_en_o,
  output logic [CW-1:0] cnt_o
);
  localparam int unsigned LAST = CHAIN_LEN + 3;

  seq_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SEQ_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (state_q)
        SEQ_IDLE: if (start_i) begin
          state_q <= SEQ_RUN;
          cnt_q   <= '0;
        end
        SEQ_RUN: if (cnt_q == CW'(LAST)) begin
          state_q <= SEQ_IDLE;
          cnt_q   <= '0;
          done_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
        default: state_q <= SEQ_IDLE;
      endcase
    end
  end

  assign busy_o   = (state_q == SEQ_RUN);
  assign done_o   = done_q;
  assign clr_o    = (state_q == SEQ_IDLE) && start_i;
  assign cmp_en_o = busy_o && (cnt_q >= CW'(CHAIN_LEN));
  assign cnt_o    = cnt_q;
endmodule

// File: rtl/flush_pattern.sv
`timescale 1ns/1ps
module flush_pattern import scan_flush_pkg::*; #(
  parameter int unsigned CHAIN_LEN = 16,
  parameter int unsigned CW        = $clog2(CHAIN_LEN + 4)
) (
  input  logic          busy_i,
  input  logic [CW-1:0] cnt_i,
  output logic          stim_o,
  output logic          exp_o
);
  logic [CW-1:0] lag;

  // bit sent CHAIN_LEN cycles ago; modulo wrap keeps bit 1 correct
  assign lag    = cnt_i - CW'(CHAIN_LEN);
  assign stim_o = busy_i & flush_bit(int'(cnt_i));
  assign exp_o  = flush_bit(int'(lag));
endmodule

// File: rtl/flush_cmp.sv
`timescale 1ns/1ps
module flush_cmp (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic cmp_en_i,
  input  logic exp_i,
  input  logic scan_out_i,
  output logic mis_o
);
  logic mis_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             mis_q <= 1'b0;
    else if (clr_i)                          mis_q <= 1'b0;
    else if (cmp_en_i && (scan_out_i != exp_i)) mis_q <= 1'b1;
  end

  assign mis_o = mis_q;
endmodule

// File: rtl/scan_flush_tester.sv
`timescale 1ns/1ps
module scan_flush_tester #(
  parameter int unsigned NUM_CHAINS = 2,
  parameter int unsigned CHAIN_LEN  = 16
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  start_i,
  input  logic [NUM_CHAINS-1:0] scan_out_i,
  output logic [NUM_CHAINS-1:0] scan_in_o,
  output logic                  test_ctrl_o,
  output logic                  busy_o,
  output logic                  done_o,
  output logic                  fail_o
);
  localparam int unsigned CW = $clog2(CHAIN_LEN + 4);

  logic          busy, clr, cmp_en, stim, exp_bit;
  logic [CW-1:0] cnt;
  logic [NUM_CHAINS-1:0] mis;

  flush_seq #(.CHAIN_LEN(CHAIN_LEN), .CW(CW)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start_i),
    .busy_o   (busy),
    .done_o   (done_o),
    .clr_o    (clr),
    .cmp_en_o (cmp_en),
    .cnt_o    (cnt)
  );

  flush_pattern #(.CHAIN_LEN(CHAIN_LEN), .CW(CW)) u_pat (
    .busy_i (busy),
    .cnt_i  (cnt),
    .stim_o (stim),
    .exp_o  (exp_bit)
  );

  for (genvar c = 0; c < NUM_CHAINS; c++) begin : g_chain
    assign scan_in_o[c] = stim;
    flush_cmp u_cmp (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .clr_i      (clr),
      .cmp_en_i   (cmp_en),
      .exp_i      (exp_bit),
      .scan_out_i (scan_out_i[c]),
      .mis_o      (mis[c])
    );
  end

  assign busy_o      = busy;
  assign test_ctrl_o = ~busy;
  assign fail_o      = |mis;
endmodule

// File: rtl/scan_flush_tester_chk.sv
`timescale 1ns/1ps
module scan_flush_tester_chk #(
  parameter int unsigned NUM_CHAINS = 2
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  start_i,
  input logic [NUM_CHAINS-1:0] scan_in_o,
  input logic                  test_ctrl_o,
  input logic                  busy_o,
  input logic                  done_o,
  input logic                  fail_o
);
  a_r2_scan_mode_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> !test_ctrl_o);
  a_r2_normal_mode_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> test_ctrl_o);
  a_r3_idle_scan_in_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (scan_in_o == '0));
  a_r3_chains_equal: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (scan_in_o == '0 || scan_in_o == '1));
  a_r5_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r5_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
  a_r5_done_on_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  a_r6_fail_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> $stable(fail_o));
  a_r6_fail_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> !fail_o);
  a_r7_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> (busy_o || done_o));
endmodule

bind scan_flush_tester scan_flush_tester_chk #(.NUM_CHAINS(NUM_CHAINS)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .scan_in_o   (scan_in_o),
  .test_ctrl_o (test_ctrl_o),
  .busy_o      (busy_o),
  .done_o      (done_o),
  .fail_o      (fail_o)
);

// File: tb/scan_flush_tester_tb_top.sv
`timescale 1ns/1ps
module scan_flush_tester_tb_top;
  localparam int N = 2;
  localparam int L = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N-1:0] scan_out, scan_in;
  logic         tc, busy, done, fail;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  scan_flush_tester #(.NUM_CHAINS(N), .CHAIN_LEN(L)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .scan_out_i(scan_out),
    .scan_in_o(scan_in), .test_ctrl_o(tc), .busy_o(busy), .done_o(done),
    .fail_o(fail)
  );

  // chain model with fault injection: mode 0 none, 1 sa0, 2 sa1, 3 invert
  logic [L-1:0] sr [N];
  logic [3:0]   seen [N][L];
  int           f_mode [N];
  int           f_pos [N];
  logic         load_en = 1'b0;
  logic [L-1:0] load_val = '0;

  function automatic logic cell_q(int c, int j);
    if (j != f_pos[c]) return sr[c][j];
    case (f_mode[c])
      1: return 1'b0;
      2: return 1'b1;
      3: return ~sr[c][j];
      default: return sr[c][j];
    endcase
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < N; c++) begin
      if (load_en) begin
        sr[c] <= load_val;
        for (int j = 0; j < L; j++) seen[c][j] <= '0;
      end else if (tc === 1'b0) begin
        for (int j = 0; j < L; j++) begin
          logic nv;
          nv = (j == 0) ? scan_in[c] : cell_q(c, j - 1);
          sr[c][j] <= nv;
          seen[c][j][{sr[c][j], nv}] <= 1'b1;
        end
      end
    end
  end

  always_comb for (int c = 0; c < N; c++) scan_out[c] = cell_q(c, L - 1);

  task automatic check(bit ok, string req, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic preload(logic [L-1:0] v);
    @(negedge clk);
    load_val = v;
    load_en  = 1'b1;
    @(negedge clk);
    load_en  = 1'b0;
  endtask

  task automatic set_fault(int c, int mode, int pos);
    for (int i = 0; i < N; i++) f_mode[i] = 0;
    f_mode[c] = mode;
    f_pos[c]  = pos;
  endtask

  // one run; mid_start > 0 pulses start again in that run cycle
  task automatic run_flush(bit exp_fail, string tag, int mid_start);
    bit pat_ok = 1, mode_ok = 1;
    @(negedge clk);
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
    for (int k = 0; k < L + 4; k++) begin
      logic eb;
      eb = k[1];
      if (scan_in !== {N{eb}}) pat_ok = 0;
      if (busy !== 1'b1 || tc !== 1'b0 || done !== 1'b0) mode_ok = 0;
      if (k == mid_start && mid_start > 0) start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
    end
    check(pat_ok, {"R3 stream ", tag}, pat_ok, 1);
    check(mode_ok, {"R2/R7 busy window ", tag}, mode_ok, 1);
    check(done === 1'b1 && busy === 1'b0 && tc === 1'b1, {"R5 done at end ", tag},
          done, 1);
    check(fail === exp_fail, {"R6/R8 fail result ", tag}, fail, exp_fail);
    @(posedge clk); #1;
    check(done === 1'b0 && busy === 1'b0, {"R5 done one cycle ", tag}, done, 0);
  endtask

  task automatic t_reset;
    check(busy === 0 && done === 0 && fail === 0, "R1 reset flags",
          {busy, done, fail}, 0);
    check(tc === 1'b1 && scan_in === '0, "R1 reset modes", {tc, scan_in}, 4);
  endtask

  task automatic t_clean_garbage;
    bit all4 = 1;
    set_fault(0, 0, 0);
    preload({(L/2){2'b10}});
    run_flush(0, "R4 garbage ignored", 0);
    for (int c = 0; c < N; c++)
      for (int j = 0; j < L; j++) if (seen[c][j] !== 4'hF) all4 = 0;
    check(all4, "R9 all four transitions", all4, 1);
    preload('1);
    run_flush(0, "R4 ones ignored", 0);
  endtask

  task automatic t_faults;
    set_fault(1, 1, 5);
    preload('0);
    run_flush(1, "R8 sa0 chain1", 0);
    set_fault(0, 2, 0);
    preload('0);
    run_flush(1, "R8 sa1 chain0", 0);
    set_fault(1, 3, L - 1);
    preload('0);
    run_flush(1, "R8 invert chain1", 0);
  endtask

  task automatic t_sticky_and_clear;
    repeat (5) @(posedge clk);
    #1;
    check(fail === 1'b1, "R6 fail held idle", fail, 1);
    set_fault(0, 0, 0);
    run_flush(0, "R6 cleared on start", 0);
  endtask

  task automatic t_start_busy;
    set_fault(0, 0, 0);
    run_flush(0, "R7 start while busy", 3);
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin f_mode[c] = 0; f_pos[c] = 0; end
    repeat (3) @(posedge clk);
    #1;
    t_reset();
    rst_n = 1'b1;
    @(posedge clk); #1;
    t_reset();
    t_clean_garbage();
    t_faults();
    t_sticky_and_clear();
    t_start_busy();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule